// File: doc/BRIEF.md
# Debug Breakpoint Match and Status Unit

This unit watches a processor's instruction-fetch and data-access addresses and compares them against four programmable breakpoint addresses. Each breakpoint has a length qualifier, which sets how many low address bits are ignored, and an access-kind qualifier: execute, data write, or data read/write. A breakpoint raises a debug exception only when it matches and its local or global enable is set. An execute match is reported as a fault. A data match is reported as a trap.

A sticky status register records why the exception was taken. It has one flag per breakpoint and separate flags for a general-detect violation, a single-step trap and a task-switch trap. Hardware only sets these flags, and software clears them by writing the register. The unit also models three more pieces of behaviour. Local enables are dropped on a task switch. A resume input suppresses execute breakpoints. A general-detect bit locks the debug registers: an access attempted while it is set raises a fault, and the bit is released automatically.

Software reaches the registers through a simple select/enable port. Read data is registered and is returned in the cycle after the access. The exception request is a one-cycle pulse in the cycle after the event that caused it.

Top module: `dbg_bp_unit`

## Requirements
- R1: After reset, all breakpoint addresses and the control and status registers read 0, and exc_vld_o and exc_fault_o are 0.
- R2: Address match ignores low bits according to length code (bits 18+4i..19+4i of control). Code 00 compares all bits. Code 01 ignores bit 0. Code 11 ignores bits 1:0. Code 10 compares all bits.
- R3: Kind code (bits 16+4i..17+4i of control) 00 matches only fetches. Code 01 matches only data writes. Code 11 matches data reads and writes. Code 10 never matches.
- R4: A breakpoint raises an exception only if it matches and its local enable (control bit i) or its global enable (control bit 4+i) is set.
- R5: When any enabled breakpoint matches, status bit i is set for every breakpoint i matching in that cycle, enabled or not. A match with no enabled breakpoint sets no flag.
- R6: An exception appears on exc_vld_o one cycle after its event, as a single-cycle pulse. exc_fault_o is 1 for an execute hit and 0 for a data-only hit.
- R7: Status bits are never cleared by hardware. A status write (select 4) loads the written bits 6:0, ORed with any flags set in the same cycle.
- R8: A task_sw_i pulse clears control bits 3:0 and leaves the global enables in bits 7:4 unchanged.
- R9: While control bit 8 is set, any register access is blocked. A write has no effect and a read returns 0. The access raises a fault, sets status bit 4 and clears control bit 8.
- R10: step_i sets status bit 5 and raises a trap. task_sw_i together with task_trap_i sets status bit 6 and raises a trap.
- R11: When resume_i is high, an execute breakpoint does not match the current fetch.
- R12: When a fault and a trap occur in the same cycle, the exception is reported as a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 3 | 0-3 breakpoint address, 4 status, 5 control |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered (cycle after access) |
| fetch_vld_i | input | 1 | Instruction fetch valid |
| fetch_addr_i | input | 32 | Fetch address |
| resume_i | input | 1 | Suppress execute breakpoints this cycle |
| data_vld_i | input | 1 | Data access valid |
| data_we_i | input | 1 | Data access is a write |
| data_addr_i | input | 32 | Data address |
| step_i | input | 1 | Single-step trap event |
| task_sw_i | input | 1 | Task switch event |
| task_trap_i | input | 1 | Entered task has its trap bit set |
| exc_vld_o | output | 1 | Debug exception request pulse |
| exc_fault_o | output | 1 | 1 = fault, 0 = trap |

## Verification
On every cycle, the assertions check several properties. Status flags never fall without a software write. A task switch always clears the local enables and keeps the global ones. A blocked access always produces a fault, sets its status flag and releases the lock. A combined fault and trap resolves to a fault. The bench's scenarios are needed for behaviour that depends on register contents: the length masks at range edges, the reserved kind code, disabled breakpoints that pick up a flag only alongside an enabled hit, resume suppression, and the exact status and control values read back through the port.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;
  localparam int unsigned NUM_BP = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned ST_W   = 7;

  typedef enum logic [1:0] {
    KIND_EXEC = 2'b00,
    KIND_WR   = 2'b01,
    KIND_RSVD = 2'b10,
    KIND_RW   = 2'b11
  } bp_kind_e;

  typedef enum logic [1:0] {
    LEN_1 = 2'b00,
    LEN_2 = 2'b01,
    LEN_X = 2'b10,
    LEN_4 = 2'b11
  } bp_len_e;

  localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;

  localparam int unsigned CTRL_GD  = 8;
  localparam int unsigned CTRL_FLD = 16;  // per-bp: kind at +4i, len at +4i+2
  localparam int unsigned ST_GD    = 4;
  localparam int unsigned ST_STEP  = 5;
  localparam int unsigned ST_TASK  = 6;
endpackage

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp
  import dbg_bp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] bp_addr_i,
  input  logic [1:0]    kind_i,
  input  logic [1:0]    len_i,
  input  logic          fetch_vld_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          data_vld_i,
  input  logic          data_we_i,
  input  logic [AW-1:0] data_addr_i,
  output logic          exec_hit_o,
  output logic          data_hit_o
);
  logic [AW-1:0] mask;
  logic          fetch_eq, data_eq, kind_ok;

  always_comb begin
    mask = '1;
    if (len_i == LEN_2) mask[0] = 1'b0;
    if (len_i == LEN_4) mask[1:0] = 2'b00;
  end

  assign fetch_eq = ((fetch_addr_i ^ bp_addr_i) & mask) == '0;
  assign data_eq  = ((data_addr_i ^ bp_addr_i) & mask) == '0;
  assign kind_ok  = (kind_i == KIND_RW) || (kind_i == KIND_WR && data_we_i);

  assign exec_hit_o = fetch_vld_i && kind_i == KIND_EXEC && fetch_eq;
  assign data_hit_o = data_vld_i && kind_ok && data_eq;
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_bp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          task_sw_i,
  input  logic          gd_viol_i,
  output logic [DW-1:0] ctrl_o
);
  localparam logic [DW-1:0] WMASK =
    DW'({{(DW-CTRL_FLD){1'b1}}, {(CTRL_FLD-CTRL_GD-1){1'b0}}, {(CTRL_GD+1){1'b1}}});

  logic [DW-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = wdata_i & WMASK;
    if (task_sw_i) ctrl_d[NUM_BP-1:0] = '0;
    if (gd_viol_i) ctrl_d[CTRL_GD] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;

  assign ctrl_o = ctrl_q;

  AST_TASK_CLR_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_sw_i |=> ctrl_q[NUM_BP-1:0] == '0); // R8
  AST_TASK_KEEP_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_sw_i && !wr_i) |=> ctrl_q[2*NUM_BP-1:NUM_BP] == $past(ctrl_q[2*NUM_BP-1:NUM_BP])); // R8
  AST_GD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gd_viol_i |=> !ctrl_q[CTRL_GD]); // R9
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_bp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [ST_W-1:0] wdata_i,
  input  logic [ST_W-1:0] set_i,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   st_q <= '0;
    else if (wr_i) st_q <= wdata_i | set_i;
    else           st_q <= st_q | set_i;

  assign status_o = st_q;

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (st_q & $past(st_q)) == $past(st_q)); // R7
  AST_STATUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (st_q & $past(set_i)) == $past(set_i)); // R7
endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit
  import dbg_bp_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_en_i,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             fetch_vld_i,
  input  logic [AW-1:0]    fetch_addr_i,
  input  logic             resume_i,
  input  logic             data_vld_i,
  input  logic             data_we_i,
  input  logic [AW-1:0]    data_addr_i,
  input  logic             step_i,
  input  logic             task_sw_i,
  input  logic             task_trap_i,
  output logic             exc_vld_o,
  output logic             exc_fault_o
);
  logic [DW-1:0]     ctrl;
  logic [ST_W-1:0]   status, st_set;
  logic [AW-1:0]     bp_addr [NUM_BP];
  logic [NUM_BP-1:0] exec_raw, exec_hit, data_hit, cond, bp_en;
  logic              gd_viol, acc_ok, wr_ok, rd_ok;
  logic              any_en, exec_en, data_en, task_trap, fault, trap;
  logic [DW-1:0]     rd_val, rdata_q;
  logic              exc_vld_q, exc_fault_q;

  assign gd_viol = reg_en_i && ctrl[CTRL_GD];
  assign acc_ok  = reg_en_i && !ctrl[CTRL_GD];
  assign wr_ok   = acc_ok && reg_we_i;
  assign rd_ok   = acc_ok && !reg_we_i;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic [AW-1:0] addr_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) addr_q <= '0;
      else if (wr_ok && reg_sel_i == SEL_W'(i)) addr_q <= reg_wdata_i[AW-1:0];
    assign bp_addr[i] = addr_q;

    dbg_bp_cmp #(.AW(AW)) u_cmp (
      .bp_addr_i    (addr_q),
      .kind_i       (ctrl[CTRL_FLD+4*i +: 2]),
      .len_i        (ctrl[CTRL_FLD+4*i+2 +: 2]),
      .fetch_vld_i  (fetch_vld_i),
      .fetch_addr_i (fetch_addr_i),
      .data_vld_i   (data_vld_i),
      .data_we_i    (data_we_i),
      .data_addr_i  (data_addr_i),
      .exec_hit_o   (exec_raw[i]),
      .data_hit_o   (data_hit[i])
    );
  end

  assign exec_hit  = resume_i ? '0 : exec_raw;
  assign cond      = exec_hit | data_hit;
  assign bp_en     = ctrl[NUM_BP-1:0] | ctrl[2*NUM_BP-1:NUM_BP];
  assign any_en    = |(cond & bp_en);
  assign exec_en   = |(exec_hit & bp_en);
  assign data_en   = |(data_hit & bp_en);
  assign task_trap = task_sw_i && task_trap_i;

  always_comb begin
    st_set = '0;
    if (any_en) st_set[NUM_BP-1:0] = cond;
    st_set[ST_GD]   = gd_viol;
    st_set[ST_STEP] = step_i;
    st_set[ST_TASK] = task_trap;
  end

  assign fault = exec_en || gd_viol;
  assign trap  = data_en || step_i || task_trap;

  dbg_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ok && reg_sel_i == SEL_CTRL),
    .wdata_i   (reg_wdata_i),
    .task_sw_i (task_sw_i),
    .gd_viol_i (gd_viol),
    .ctrl_o    (ctrl)
  );

  dbg_status_reg u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_ok && reg_sel_i == SEL_STAT),
    .wdata_i  (reg_wdata_i[ST_W-1:0]),
    .set_i    (st_set),
    .status_o (status)
  );

  always_comb begin
    rd_val = '0;
    if (reg_sel_i < SEL_W'(NUM_BP)) rd_val = DW'(bp_addr[reg_sel_i[1:0]]);
    else if (reg_sel_i == SEL_STAT) rd_val = DW'(status);
    else if (reg_sel_i == SEL_CTRL) rd_val = ctrl;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_q     <= '0;
      exc_vld_q   <= 1'b0;
      exc_fault_q <= 1'b0;
    end else begin
      rdata_q     <= rd_ok ? rd_val : '0;
      exc_vld_q   <= fault || trap;
      exc_fault_q <= fault;  // fault wins over a same-cycle trap
    end

  assign reg_rdata_o = rdata_q;
  assign exc_vld_o   = exc_vld_q;
  assign exc_fault_o = exc_fault_q;

  AST_GD_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gd_viol |=> exc_vld_o && exc_fault_o && status[ST_GD]); // R9
  AST_FAULT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && (step_i || data_en)) |=> exc_fault_o); // R12
  AST_STEP_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> exc_vld_o && status[ST_STEP]); // R10
  AST_NO_SRC_NO_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_en && !reg_en_i && !step_i && !task_trap) |=> !exc_vld_o); // R4
endmodule

// File: tb/dbg_bp_unit_test.sv
module dbg_bp_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_en, reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        fetch_vld, resume, data_vld, data_we, step, task_sw, task_trap;
  logic [31:0] fetch_addr, data_addr;
  logic        exc_vld, exc_fault;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bp_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .fetch_vld_i(fetch_vld), .fetch_addr_i(fetch_addr), .resume_i(resume),
    .data_vld_i(data_vld), .data_we_i(data_we), .data_addr_i(data_addr),
    .step_i(step), .task_sw_i(task_sw), .task_trap_i(task_trap),
    .exc_vld_o(exc_vld), .exc_fault_o(exc_fault)
  );

  // reference model
  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl, m_rdata;
  logic [6:0]  m_stat;
  logic        m_exv, m_exf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_addr[i] = 0;
      m_ctrl = 0; m_stat = 0; m_rdata = 0; m_exv = 0; m_exf = 0;
    end else begin
      bit gdv, any_en, ex_en, dt_en, tt;
      logic [3:0] hit;
      logic [31:0] nctrl, rv;
      logic [6:0] nstat;
      gdv = reg_en && m_ctrl[8];
      hit = 0; any_en = 0; ex_en = 0; dt_en = 0;
      for (int i = 0; i < 4; i++) begin
        int unsigned kind, len, size;
        logic [31:0] base;
        bit en, fh, dh;
        kind = (m_ctrl >> (16 + 4*i)) & 3;
        len  = (m_ctrl >> (18 + 4*i)) & 3;
        size = (len == 1) ? 2 : (len == 3) ? 4 : 1;
        base = m_addr[i] & ~(size - 1);
        en = m_ctrl[i] || m_ctrl[4+i];
        fh = fetch_vld && !resume && kind == 0 &&
             fetch_addr >= base && fetch_addr < base + size;
        dh = data_vld && (kind == 3 || (kind == 1 && data_we)) &&
             data_addr >= base && data_addr < base + size;
        hit[i] = fh || dh;
        if (en && fh) ex_en = 1;
        if (en && dh) dt_en = 1;
      end
      any_en = ex_en || dt_en;
      tt = task_sw && task_trap;
      rv = 0;
      if (reg_sel < 4) rv = m_addr[reg_sel];
      else if (reg_sel == 4) rv = {25'd0, m_stat};
      else if (reg_sel == 5) rv = m_ctrl;
      m_rdata = (reg_en && !reg_we && !gdv) ? rv : 0;
      nctrl = m_ctrl; nstat = m_stat;
      if (reg_en && reg_we && !gdv) begin
        if (reg_sel < 4) m_addr[reg_sel] = reg_wdata;
        else if (reg_sel == 4) nstat = reg_wdata[6:0];
        else if (reg_sel == 5) nctrl = reg_wdata & 32'hFFFF01FF;
      end
      if (task_sw) nctrl[3:0] = 0;
      if (gdv) nctrl[8] = 0;
      if (any_en) nstat[3:0] = nstat[3:0] | hit;
      if (gdv) nstat[4] = 1;
      if (step) nstat[5] = 1;
      if (tt) nstat[6] = 1;
      m_ctrl = nctrl; m_stat = nstat;
      m_exv = ex_en || gdv || dt_en || step || tt;
      m_exf = ex_en || gdv;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R6 exc_vld model", {31'd0, exc_vld}, {31'd0, m_exv});
    chk("R12 exc_fault model", {31'd0, exc_fault}, {31'd0, m_exf});
    chk("R9 rdata model", reg_rdata, m_rdata);
  endtask

  task automatic tick();
    @(posedge clk); #2; compare();
  endtask

  task automatic idle();
    reg_en = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    fetch_vld = 0; fetch_addr = 0; resume = 0;
    data_vld = 0; data_we = 0; data_addr = 0;
    step = 0; task_sw = 0; task_trap = 0;
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    idle(); reg_en = 1; reg_we = 1; reg_sel = sel; reg_wdata = d; tick(); idle();
  endtask

  task automatic rd(logic [2:0] sel, output logic [31:0] v);
    idle(); reg_en = 1; reg_sel = sel; tick(); v = reg_rdata; idle();
  endtask

  task automatic fetch(logic [31:0] a, bit res);
    idle(); fetch_vld = 1; fetch_addr = a; resume = res; tick(); idle();
  endtask

  task automatic dacc(logic [31:0] a, bit we);
    idle(); data_vld = 1; data_we = we; data_addr = a; tick(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle();
    #(3*CLK_PERIOD + 2);
    rst_n = 1;
    tick();
    chk("R1 exc after reset", {30'd0, exc_vld, exc_fault}, 0);
    rd(4, v); chk("R1 status reset", v, 0);
    rd(5, v); chk("R1 ctrl reset", v, 0);
    rd(2, v); chk("R1 addr reset", v, 0);

    // exec bp0 enabled, bp1 same address disabled
    wr(0, 32'h100); wr(1, 32'h100); wr(5, 32'h1);
    fetch(32'h100, 0);
    chk("R6 exec hit fault", {30'd0, exc_vld, exc_fault}, 32'h3);
    tick();
    chk("R6 single pulse", {31'd0, exc_vld}, 0);
    rd(4, v); chk("R5 disabled match flagged", v, 32'h3);
    wr(4, 0); rd(4, v); chk("R7 software clear", v, 0);

    // data write bp2, 4 bytes
    wr(2, 32'h200); wr(5, 32'h0D000041);
    dacc(32'h203, 1);
    chk("R6 data hit trap", {30'd0, exc_vld, exc_fault}, 32'h2);
    dacc(32'h203, 0); chk("R3 write-only ignores read", {31'd0, exc_vld}, 0);
    dacc(32'h204, 1); chk("R2 4-byte range edge", {31'd0, exc_vld}, 0);
    dacc(32'h1FF, 1); chk("R2 below range", {31'd0, exc_vld}, 0);
    rd(4, v); chk("R5 only bp2 flagged", v, 32'h4);

    // disabled bp3 alone, then together with enabled bp2
    wr(3, 32'h300); wr(5, 32'h3D000041);
    dacc(32'h300, 0); chk("R4 disabled no exc", {31'd0, exc_vld}, 0);
    rd(4, v); chk("R5 no flag without enabled hit", v, 32'h4);
    wr(3, 32'h202);
    dacc(32'h202, 1); chk("R4 enabled trap", {31'd0, exc_vld}, 1);
    rd(4, v); chk("R5 disabled co-match flagged", v, 32'hC);
    tick(); tick();
    rd(4, v); chk("R7 sticky status", v, 32'hC);

    // reserved kind on enabled bp3
    wr(3, 32'h500); wr(5, 32'h2D0000C1);
    dacc(32'h500, 1); chk("R3 reserved never matches", {31'd0, exc_vld}, 0);
    dacc(32'h500, 0); chk("R3 reserved read", {31'd0, exc_vld}, 0);

    // resume
    wr(4, 0);
    fetch(32'h100, 1); chk("R11 resume suppresses", {31'd0, exc_vld}, 0);
    rd(4, v); chk("R11 no flag on resume", v, 0);

    // task switch
    idle(); task_sw = 1; tick(); idle();
    chk("R8 plain switch no exc", {31'd0, exc_vld}, 0);
    rd(5, v); chk("R8 locals cleared globals kept", v, 32'h2D0000C0);
    idle(); task_sw = 1; task_trap = 1; tick(); idle();
    chk("R10 task trap", {30'd0, exc_vld, exc_fault}, 32'h2);
    idle(); step = 1; tick(); idle();
    chk("R10 step trap", {30'd0, exc_vld, exc_fault}, 32'h2);
    rd(4, v); chk("R10 status step and task", v, 32'h60);

    // same-cycle fault and trap
    wr(5, 32'h2D0000C1);
    idle(); fetch_vld = 1; fetch_addr = 32'h100; step = 1; tick(); idle();
    chk("R12 fault priority", {30'd0, exc_vld, exc_fault}, 32'h3);

    // 2-byte length on bp1
    wr(1, 32'h401); wr(5, 32'h2D7000E1);
    dacc(32'h400, 0); chk("R2 2-byte low byte", {31'd0, exc_vld}, 1);
    dacc(32'h402, 0); chk("R2 2-byte outside", {31'd0, exc_vld}, 0);

    // general detect
    wr(5, 32'h2D7001E1);
    wr(0, 32'hABC);
    chk("R9 blocked write faults", {30'd0, exc_vld, exc_fault}, 32'h3);
    rd(5, v); chk("R9 gd released", v, 32'h2D7000E1);
    rd(4, v); chk("R9 status bit4", (v >> 4) & 1, 1);
    rd(0, v); chk("R9 write had no effect", v, 32'h100);
    wr(5, 32'h2D7001E1);
    rd(0, v); chk("R9 blocked read returns 0", v, 0);
    chk("R9 blocked read faults", {30'd0, exc_vld, exc_fault}, 32'h3);
    rd(5, v); chk("R9 ctrl after read lock", v, 32'h2D7000E1);

    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule